// File: doc/BRIEF.md
# Branch Resolve and Squash Control

This block steers the fetch address of a five-stage pipeline whose branch and jump outcomes are known only in the execute stage, two cycles after fetch. It owns the fetch address register. Each cycle it chooses among three next addresses: the sequential one, the current one held, or the redirect target. It also drives the controls that turn the younger instructions in the fetch/decode and decode/execute pipeline registers into bubbles.

A build-time mode sets the policy. In the default mode fetch assumes each branch falls through. When a taken transfer reaches execute, both younger instructions are squashed, which costs two bubbles. In the delay-slot mode the instruction right after a branch always completes. A taken transfer then squashes only the instruction being fetched, which costs one bubble. A taken redirect always wins over a concurrent data-hazard stall. Instructions squashed on their way into decode/execute leave with their register-write and memory-write enables forced low.

Top module: `branch_squash_ctl`

## Requirements
- R1: While `rst` is high, `npc_sel` is 01 (hold), `ifid_flush` and `idex_flush` are both 1, both outgoing write enables are 0, and `fetch_pc` loads `RESET_PC` at the clock edge.
- R2: With `ex_taken` and `hz_stall` low (including a resolved not-taken branch), `npc_sel` is 00 (sequential), no flush or hold is raised, the write enables pass through unchanged, and `fetch_pc` advances by `STEP` at the next edge.
- R3: With `hz_stall` high and `ex_taken` low, `npc_sel` is 01, `fetch_pc` keeps its value, `ifid_hold` and `idex_flush` are 1, and `ifid_flush` is 0.
- R4: In the default mode, a high `ex_taken` gives `npc_sel` 10 (target), raises both `ifid_flush` and `idex_flush` (two bubbles), keeps `ifid_hold` low, and `fetch_pc` equals `ex_target` after the edge.
- R5: In the default mode, `ex_taken` overrides `hz_stall`: the outputs are exactly those of R4.
- R6: In delay-slot mode, with `ex_taken` high and `hz_stall` low, `npc_sel` is 10, only `ifid_flush` is raised (one bubble), the slot's write enables pass through, and `fetch_pc` equals `ex_target` after the edge.
- R7: In delay-slot mode, with `ex_taken` and `hz_stall` both high, `npc_sel` is 10 and `fetch_pc` loads `ex_target`. `ifid_hold` is 1 so that the slot stays in decode, `idex_flush` is 1, and `ifid_flush` is 0.
- R8: Whenever `idex_flush` is 1, `idex_rf_we` and `idex_mem_we` are 0.
- R9: `ifid_flush` and `ifid_hold` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_taken | input | 1 | Control transfer in execute is taken |
| ex_target | input | AW | Redirect address from execute |
| hz_stall | input | 1 | Data-hazard stall request from decode |
| id_rf_we | input | 1 | Register-write enable of the decode-stage instruction |
| id_mem_we | input | 1 | Memory-write enable of the decode-stage instruction |
| fetch_pc | output | AW | Current fetch address |
| npc_sel | output | 2 | Next-address choice: 00 sequential, 01 hold, 10 target |
| ifid_flush | output | 1 | Clear fetch/decode register to a no-op |
| ifid_hold | output | 1 | Keep fetch/decode register contents |
| idex_flush | output | 1 | Insert a bubble into decode/execute |
| idex_rf_we | output | 1 | Register-write enable entering decode/execute |
| idex_mem_we | output | 1 | Memory-write enable entering decode/execute |

## Verification
The assertions take `ex_taken` to be raised only for a real taken transfer in execute. They also take every input as settled for the whole cycle. Since a bubble follows each squash, a taken flag never arrives in two back-to-back cycles. The bench changes inputs only just after the falling edge, and it always puts an untaken cycle between two taken ones. Both modes are instanced side by side on the same stimulus.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'b00,
        NPC_HOLD   = 2'b01,
        NPC_TARGET = 2'b10
    } npc_sel_e;

    typedef struct packed {
        npc_sel_e sel;
        logic     ifid_flush;
        logic     ifid_hold;
        logic     idex_flush;
    } squash_ctl_t;

    function automatic squash_ctl_t ctl_make(npc_sel_e s, logic f_ifid,
                                             logic h_ifid, logic f_idex);
        squash_ctl_t c;
        c.sel        = s;
        c.ifid_flush = f_ifid;
        c.ifid_hold  = h_ifid;
        c.idex_flush = f_idex;
        return c;
    endfunction

endpackage

// File: rtl/bsq_resolve.sv
module bsq_resolve
    import bsq_pkg::*;
#(
    parameter bit SLOT_MODE = 1'b0
) (
    input  logic        rst,
    input  logic        ex_taken,
    input  logic        hz_stall,
    output squash_ctl_t ctl
);

    generate
        if (SLOT_MODE) begin : g_slot
            // Slot instruction in decode survives a taken transfer.
            always_comb begin
                if (rst)
                    ctl = ctl_make(NPC_HOLD, 1'b1, 1'b0, 1'b1);
                else if (ex_taken && hz_stall)
                    ctl = ctl_make(NPC_TARGET, 1'b0, 1'b1, 1'b1);
                else if (ex_taken)
                    ctl = ctl_make(NPC_TARGET, 1'b1, 1'b0, 1'b0);
                else if (hz_stall)
                    ctl = ctl_make(NPC_HOLD, 1'b0, 1'b1, 1'b1);
                else
                    ctl = ctl_make(NPC_SEQ, 1'b0, 1'b0, 1'b0);
            end
        end else begin : g_pred
            // Fall-through guess: both younger instructions are wrong path.
            always_comb begin
                if (rst)
                    ctl = ctl_make(NPC_HOLD, 1'b1, 1'b0, 1'b1);
                else if (ex_taken)
                    ctl = ctl_make(NPC_TARGET, 1'b1, 1'b0, 1'b1);
                else if (hz_stall)
                    ctl = ctl_make(NPC_HOLD, 1'b0, 1'b1, 1'b1);
                else
                    ctl = ctl_make(NPC_SEQ, 1'b0, 1'b0, 1'b0);
            end
        end
    endgenerate

endmodule

// File: rtl/bsq_pcreg.sv
module bsq_pcreg
    import bsq_pkg::*;
#(
    parameter int unsigned      AW       = 32,
    parameter int unsigned      STEP     = 4,
    parameter logic [AW-1:0]    RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  npc_sel_e      sel,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] INC = AW'(STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= RESET_PC;
        end else begin
            unique case (sel)
                NPC_SEQ:    pc <= pc + INC;
                NPC_TARGET: pc <= target;
                default:    pc <= pc;
            endcase
        end
    end

endmodule

// File: rtl/bsq_wegate.sv
module bsq_wegate #(
    parameter int unsigned N = 2
) (
    input  logic         kill,
    input  logic [N-1:0] en_in,
    output logic [N-1:0] en_out
);

    always_comb begin
        for (int i = 0; i < N; i++)
            en_out[i] = en_in[i] & ~kill;
    end

endmodule

// File: rtl/branch_squash_ctl.sv
module branch_squash_ctl
    import bsq_pkg::*;
#(
    parameter int unsigned   AW        = 32,
    parameter int unsigned   STEP      = 4,
    parameter logic [AW-1:0] RESET_PC  = '0,
    parameter bit            SLOT_MODE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ex_taken,
    input  logic [AW-1:0] ex_target,
    input  logic          hz_stall,
    input  logic          id_rf_we,
    input  logic          id_mem_we,
    output logic [AW-1:0] fetch_pc,
    output logic [1:0]    npc_sel,
    output logic          ifid_flush,
    output logic          ifid_hold,
    output logic          idex_flush,
    output logic          idex_rf_we,
    output logic          idex_mem_we
);

    localparam int unsigned WE_N = 2;

    squash_ctl_t       ctl;
    logic [WE_N-1:0]   we_in;
    logic [WE_N-1:0]   we_out;

    bsq_resolve #(.SLOT_MODE(SLOT_MODE)) u_resolve (
        .rst      (rst),
        .ex_taken (ex_taken),
        .hz_stall (hz_stall),
        .ctl      (ctl)
    );

    bsq_pcreg #(.AW(AW), .STEP(STEP), .RESET_PC(RESET_PC)) u_pcreg (
        .clk    (clk),
        .rst    (rst),
        .sel    (ctl.sel),
        .target (ex_target),
        .pc     (fetch_pc)
    );

    assign we_in = {id_mem_we, id_rf_we};

    bsq_wegate #(.N(WE_N)) u_wegate (
        .kill   (ctl.idex_flush),
        .en_in  (we_in),
        .en_out (we_out)
    );

    assign npc_sel     = ctl.sel;
    assign ifid_flush  = ctl.ifid_flush;
    assign ifid_hold   = ctl.ifid_hold;
    assign idex_flush  = ctl.idex_flush;
    assign idex_rf_we  = we_out[0];
    assign idex_mem_we = we_out[1];

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
    parameter int unsigned   AW        = 32,
    parameter int unsigned   STEP      = 4,
    parameter logic [AW-1:0] RESET_PC  = '0,
    parameter bit            SLOT_MODE = 1'b0
) (
    input logic          clk,
    input logic          rst,
    input logic          ex_taken,
    input logic [AW-1:0] ex_target,
    input logic          hz_stall,
    input logic          id_rf_we,
    input logic          id_mem_we,
    input logic [AW-1:0] fetch_pc,
    input logic [1:0]    npc_sel,
    input logic          ifid_flush,
    input logic          ifid_hold,
    input logic          idex_flush,
    input logic          idex_rf_we,
    input logic          idex_mem_we
);

    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> fetch_pc == RESET_PC);

    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!ex_taken && !hz_stall) |=> fetch_pc == AW'($past(fetch_pc) + AW'(STEP)));

    a_r3_stall_holds_pc: assert property (@(posedge clk) disable iff (rst)
        (hz_stall && !ex_taken) |=> $stable(fetch_pc));

    a_r4_redirect_pc: assert property (@(posedge clk) disable iff (rst)
        ex_taken |=> fetch_pc == $past(ex_target));

    a_r8_squash_kills_we: assert property (@(posedge clk) disable iff (rst)
        idex_flush |-> (!idex_rf_we && !idex_mem_we));

    a_r9_flush_hold_excl: assert property (@(posedge clk) disable iff (rst)
        !(ifid_flush && ifid_hold));

    generate
        if (SLOT_MODE) begin : g_slot_chk
            a_r6_slot_kept: assert property (@(posedge clk) disable iff (rst)
                (ex_taken && !hz_stall) |->
                    (ifid_flush && !idex_flush && idex_rf_we == id_rf_we
                     && idex_mem_we == id_mem_we));

            a_r7_slot_stall: assert property (@(posedge clk) disable iff (rst)
                (ex_taken && hz_stall) |->
                    (npc_sel == 2'b10 && ifid_hold && idex_flush && !ifid_flush));
        end else begin : g_pred_chk
            a_r4_two_bubbles: assert property (@(posedge clk) disable iff (rst)
                ex_taken |-> (ifid_flush && idex_flush && !ifid_hold));

            a_r5_taken_over_stall: assert property (@(posedge clk) disable iff (rst)
                (ex_taken && hz_stall) |-> (npc_sel == 2'b10 && !ifid_hold));
        end
    endgenerate

endmodule

bind branch_squash_ctl bsq_checker #(
    .AW(AW), .STEP(STEP), .RESET_PC(RESET_PC), .SLOT_MODE(SLOT_MODE)
) u_chk (
    .clk(clk), .rst(rst), .ex_taken(ex_taken), .ex_target(ex_target),
    .hz_stall(hz_stall), .id_rf_we(id_rf_we), .id_mem_we(id_mem_we),
    .fetch_pc(fetch_pc), .npc_sel(npc_sel), .ifid_flush(ifid_flush),
    .ifid_hold(ifid_hold), .idex_flush(idex_flush),
    .idex_rf_we(idex_rf_we), .idex_mem_we(idex_mem_we)
);

// File: tb/sim_branch_squash_ctl.sv
module sim_branch_squash_ctl;

    localparam int unsigned   AW   = 32;
    localparam int unsigned   STEP = 4;
    localparam logic [AW-1:0] RPC  = 32'h0000_0100;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          ex_taken = 1'b0;
    logic [AW-1:0] ex_target = '0;
    logic          hz_stall = 1'b0;
    logic          id_rf_we = 1'b0;
    logic          id_mem_we = 1'b0;

    logic [AW-1:0] pc_a, pc_b;
    logic [1:0]    sel_a, sel_b;
    logic          iff_a, iff_b, ifh_a, ifh_b, ixf_a, ixf_b;
    logic          rw_a, rw_b, mw_a, mw_b;

    int n_chk = 0;
    int n_err = 0;
    logic [AW-1:0] exp_pc;

    branch_squash_ctl #(.AW(AW), .STEP(STEP), .RESET_PC(RPC), .SLOT_MODE(1'b0)) u0 (
        .clk(clk), .rst(rst), .ex_taken(ex_taken), .ex_target(ex_target),
        .hz_stall(hz_stall), .id_rf_we(id_rf_we), .id_mem_we(id_mem_we),
        .fetch_pc(pc_a), .npc_sel(sel_a), .ifid_flush(iff_a), .ifid_hold(ifh_a),
        .idex_flush(ixf_a), .idex_rf_we(rw_a), .idex_mem_we(mw_a)
    );

    branch_squash_ctl #(.AW(AW), .STEP(STEP), .RESET_PC(RPC), .SLOT_MODE(1'b1)) u1 (
        .clk(clk), .rst(rst), .ex_taken(ex_taken), .ex_target(ex_target),
        .hz_stall(hz_stall), .id_rf_we(id_rf_we), .id_mem_we(id_mem_we),
        .fetch_pc(pc_b), .npc_sel(sel_b), .ifid_flush(iff_b), .ifid_hold(ifh_b),
        .idex_flush(ixf_b), .idex_rf_we(rw_b), .idex_mem_we(mw_b)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Inputs change just after the falling edge; outputs sampled 1 ns later.
    task automatic drive(input logic tk, input logic [AW-1:0] tg, input logic st,
                         input logic rw, input logic mw);
        @(negedge clk);
        ex_taken = tk; ex_target = tg; hz_stall = st; id_rf_we = rw; id_mem_we = mw;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        drive(1'b0, '0, 1'b0, 1'b1, 1'b1);
        chk("R1 sel u0", 64'(sel_a), 64'h1);
        chk("R1 sel u1", 64'(sel_b), 64'h1);
        chk("R1 flushes u0", 64'({iff_a, ixf_a}), 64'h3);
        chk("R1 flushes u1", 64'({iff_b, ixf_b}), 64'h3);
        chk("R1 we u0", 64'({rw_a, mw_a}), 64'h0);
        tick();
        chk("R1 pc u0", 64'(pc_a), 64'(RPC));
        chk("R1 pc u1", 64'(pc_b), 64'(RPC));
        rst = 1'b0;
        exp_pc = RPC;
    endtask

    task automatic t_seq(input logic rw, input logic mw);
        drive(1'b0, 32'hDEAD_BEEC, 1'b0, rw, mw);
        chk("R2 sel u0", 64'(sel_a), 64'h0);
        chk("R2 sel u1", 64'(sel_b), 64'h0);
        chk("R2 ctl u0", 64'({iff_a, ifh_a, ixf_a}), 64'h0);
        chk("R2 ctl u1", 64'({iff_b, ifh_b, ixf_b}), 64'h0);
        chk("R2 we u0", 64'({rw_a, mw_a}), 64'({rw, mw}));
        chk("R2 we u1", 64'({rw_b, mw_b}), 64'({rw, mw}));
        tick();
        exp_pc = exp_pc + AW'(STEP);
        chk("R2 pc u0", 64'(pc_a), 64'(exp_pc));
        chk("R2 pc u1", 64'(pc_b), 64'(exp_pc));
    endtask

    task automatic t_stall();
        drive(1'b0, 32'h0000_0800, 1'b1, 1'b1, 1'b1);
        chk("R3 sel u0", 64'(sel_a), 64'h1);
        chk("R3 sel u1", 64'(sel_b), 64'h1);
        chk("R3 ctl u0", 64'({iff_a, ifh_a, ixf_a}), 64'h3);
        chk("R3 ctl u1", 64'({iff_b, ifh_b, ixf_b}), 64'h3);
        chk("R8 we stall u0", 64'({rw_a, mw_a}), 64'h0);
        tick();
        chk("R3 pc u0", 64'(pc_a), 64'(exp_pc));
        chk("R3 pc u1", 64'(pc_b), 64'(exp_pc));
    endtask

    task automatic t_taken(input logic [AW-1:0] tg);
        drive(1'b1, tg, 1'b0, 1'b1, 1'b1);
        chk("R4 sel u0", 64'(sel_a), 64'h2);
        chk("R4 two bubbles u0", 64'({iff_a, ifh_a, ixf_a}), 64'h5);
        chk("R8 we taken u0", 64'({rw_a, mw_a}), 64'h0);
        chk("R6 sel u1", 64'(sel_b), 64'h2);
        chk("R6 one bubble u1", 64'({iff_b, ifh_b, ixf_b}), 64'h4);
        chk("R6 slot we u1", 64'({rw_b, mw_b}), 64'h3);
        tick();
        exp_pc = tg;
        chk("R4 pc u0", 64'(pc_a), 64'(exp_pc));
        chk("R6 pc u1", 64'(pc_b), 64'(exp_pc));
    endtask

    task automatic t_taken_stall(input logic [AW-1:0] tg);
        drive(1'b1, tg, 1'b1, 1'b1, 1'b0);
        chk("R5 sel u0", 64'(sel_a), 64'h2);
        chk("R5 ctl u0", 64'({iff_a, ifh_a, ixf_a}), 64'h5);
        chk("R7 sel u1", 64'(sel_b), 64'h2);
        chk("R7 ctl u1", 64'({iff_b, ifh_b, ixf_b}), 64'h3);
        chk("R9 excl u1", 64'(iff_b & ifh_b), 64'h0);
        chk("R8 we u1", 64'({rw_b, mw_b}), 64'h0);
        tick();
        exp_pc = tg;
        chk("R5 pc u0", 64'(pc_a), 64'(exp_pc));
        chk("R7 pc u1", 64'(pc_b), 64'(exp_pc));
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_seq(1'b1, 1'b1);
        t_seq(1'b1, 1'b0);
        t_seq(1'b0, 1'b1);
        t_stall();
        t_seq(1'b0, 1'b0);
        t_taken(32'h0000_2000);
        t_seq(1'b1, 1'b1);
        t_stall();
        t_taken_stall(32'h0000_4A40);
        t_seq(1'b1, 1'b0);
        t_taken(32'hFFFF_FFFC);
        t_seq(1'b1, 1'b1);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule